// File: doc/BRIEF.md
# Clocked Synchronous Serial Transmitter

This block serialises bytes onto a data line alongside a serial clock, with no start or stop bits. A host hands over a byte through a valid/ready port into a one-byte holding register. When the shifter is idle, or when it is finishing the last bit of a frame, the held byte is copied into the shift register. The holding register is then free again, so the host can queue the next byte while the current one is still on the wire.

The serial clock either comes from an internal divider and is driven out, or is taken from an external clock input. In the external case the block drives no clock of its own. The data line changes on falling serial-clock edges, so a receiver samples on rising edges.

If a byte is waiting by the time the last bit's rising edge arrives, the next frame follows with no gap. Otherwise a transmit-end flag is raised. The data line then keeps the last bit's value and the clock line stays high. The data-empty flag and the transmit-end flag each have an interrupt request, masked by its own enable pin.

Back-pressure rule: `wr_ready` is the data-empty flag. A byte is taken on a clock edge where `wr_valid` and `wr_ready` are both 1. While `wr_ready` is 0, the source must keep `wr_valid` and `wr_data` steady, and the holding register does not change.

Top module: `sync_ser_tx`

## Requirements
- R1: After reset, `empty`=1, `tend`=1, `wr_ready`=1, `txd`=1 and `sclk_out`=1.
- R2: An accepted write (`wr_valid`=1 and `wr_ready`=1 at a clock edge) makes `empty`=0 and `tend`=0 after that edge.
- R3: When the shifter is idle, a pending byte is copied one clock after it is accepted (internal clock mode). After that edge, `empty`=1, `txd` equals bit 0 of the byte and `sclk_out`=0.
- R4: Each frame is exactly 8 bits, sent least significant bit first. In internal mode `txd` changes only on a cycle where `sclk_out` falls, and bits are valid on rising `sclk_out`.
- R5: In internal mode each low half and each high half of `sclk_out` lasts `div`+1 clock cycles, and each frame has exactly 8 clock pulses.
- R6: With `ext_sel`=1, `sclk_out` stays 1. Bits advance on falling edges of `sclk_in`, after a two-flop synchroniser, so the receiver samples on rising edges of `sclk_in`.
- R7: If `empty`=0 at the rising clock edge of bit 7, the next frame starts on the following falling edge with no gap. Three chained frames take 47×(`div`+1) cycles from the first falling edge to the last rising edge, and `tend` stays 0 throughout.
- R8: If `empty`=1 at the rising clock edge of bit 7, `tend` becomes 1 on that edge. Afterwards `txd` holds bit 7 and `sclk_out` stays 1 until the next frame.
- R9: `irq_de` = `empty` AND `de_en`, and `irq_te` = `tend` AND `te_en`, as levels.
- R10: While `wr_ready`=0 (a byte is already held), a presented byte is not taken. It is accepted once, in order, after the held byte moves to the shifter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_sel | input | 1 | 1: serial clock from `sclk_in`; 0: internal divider |
| div | input | DIVW | Half-period of the internal clock minus one, in system cycles |
| de_en | input | 1 | Data-empty interrupt enable |
| te_en | input | 1 | Transmit-end interrupt enable |
| wr_valid | input | 1 | Host byte valid |
| wr_data | input | DW | Host byte |
| wr_ready | output | 1 | Holding register free (equals data-empty flag) |
| sclk_in | input | 1 | External serial clock |
| sclk_out | output | 1 | Generated serial clock, idle high |
| txd | output | 1 | Serial data |
| empty | output | 1 | Data-empty flag |
| tend | output | 1 | Transmit-end flag |
| irq_de | output | 1 | Data-empty interrupt request |
| irq_te | output | 1 | Transmit-end interrupt request |

## Verification
A wrong bit counter or shift register shows as a corrupted byte at the scoreboard within one frame. It can also show as a ninth clock pulse, or as a low half of the wrong length, which the monitor catches at the very next rising edge. A stale chaining decision shows as a gap between frames or a premature `tend`. Both are caught by the cycle count across a three-byte burst. A flag that fails to update is visible on `wr_ready` or an interrupt line one cycle after the write or load that should have moved it.

// File: rtl/sst_pkg.sv
package sst_pkg;
  // one-cycle strobes marking serial clock edges
  typedef struct packed {
    logic fall;
    logic rise;
  } sst_edge_t;
endpackage

// File: rtl/sst_hold.sv
module sst_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  input  logic          load,
  input  logic          end_set,
  input  logic          de_en,
  input  logic          te_en,
  output logic [DW-1:0] hold_q,
  output logic          empty,
  output logic          tend,
  output logic          irq_de,
  output logic          irq_te
);
  logic accept;
  assign accept = wr_valid && empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= '0;
      empty  <= 1'b1;
      tend   <= 1'b1;
    end else if (accept) begin
      hold_q <= wr_data;
      empty  <= 1'b0;
      tend   <= 1'b0;
    end else begin
      if (load)    empty <= 1'b1;
      if (end_set) tend  <= 1'b1;
    end
  end

  assign irq_de = empty && de_en;
  assign irq_te = tend && te_en;

  p_accept_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (!empty && !tend));
  p_held_byte_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !empty) |=> $stable(hold_q));
endmodule

// File: rtl/sst_clkgen.sv
module sst_clkgen import sst_pkg::*; #(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            busy,
  input  logic            pending,
  input  logic            sclk_q,
  input  logic [DIVW-1:0] div,
  output sst_edge_t       ev
);
  logic [DIVW-1:0] cnt;
  logic            tick;

  assign tick    = busy && (cnt >= div);
  assign ev.rise = tick && !sclk_q;
  assign ev.fall = busy ? (tick && sclk_q) : pending;

  always_ff @(posedge clk) begin
    if (!rst_n || !busy || tick) cnt <= '0;
    else                         cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sst_extedge.sv
module sst_extedge import sst_pkg::*; #(
  parameter int SYNC = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sclk_in,
  output sst_edge_t ev
);
  // SYNC synchroniser stages plus one history stage
  logic [SYNC:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) sh <= '1;
    else        sh <= {sh[SYNC-1:0], sclk_in};
  end

  assign ev.fall = sh[SYNC] && !sh[SYNC-1];
  assign ev.rise = !sh[SYNC] && sh[SYNC-1];
endmodule

// File: rtl/sst_shifter.sv
module sst_shifter import sst_pkg::*; #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  sst_edge_t     ev,
  input  logic          empty,
  input  logic [DW-1:0] hold_q,
  output logic          load,
  output logic          end_set,
  output logic          busy,
  output logic          sclk_q,
  output logic          txd
);
  localparam int BW = $clog2(DW);
  localparam logic [BW-1:0] LAST = BW'(DW - 1);

  logic [DW-1:0] shreg;
  logic [BW-1:0] bitn;
  logic          chain;
  logic          last_bit;

  assign last_bit = busy && (bitn == LAST);
  assign load     = ev.fall && (busy ? (last_bit && chain) : !empty);
  assign end_set  = ev.rise && last_bit && empty;
  assign txd      = shreg[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg  <= '1;
      bitn   <= '0;
      busy   <= 1'b0;
      chain  <= 1'b0;
      sclk_q <= 1'b1;
    end else if (load) begin
      shreg  <= hold_q;
      bitn   <= '0;
      busy   <= 1'b1;
      chain  <= 1'b0;
      sclk_q <= 1'b0;
    end else if (ev.fall && busy) begin
      if (last_bit) begin
        busy <= 1'b0;
      end else begin
        bitn   <= bitn + 1'b1;
        shreg  <= {shreg[DW-1], shreg[DW-1:1]};
        sclk_q <= 1'b0;
      end
    end else if (ev.rise && busy) begin
      sclk_q <= 1'b1;
      if (last_bit) chain <= !empty;
    end
  end

  p_idle_clock_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sclk_q);
  p_end_holds_line_r8: assert property (@(posedge clk) disable iff (!rst_n)
    end_set |=> (sclk_q && $stable(txd)));
  p_chain_no_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.fall && last_bit && chain) |=> (busy && !sclk_q && bitn == '0));
endmodule

// File: rtl/sync_ser_tx.sv
module sync_ser_tx import sst_pkg::*; #(
  parameter int DW   = 8,
  parameter int DIVW = 8,
  parameter int SYNC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ext_sel,
  input  logic [DIVW-1:0] div,
  input  logic            de_en,
  input  logic            te_en,
  input  logic            wr_valid,
  input  logic [DW-1:0]   wr_data,
  output logic            wr_ready,
  input  logic            sclk_in,
  output logic            sclk_out,
  output logic            txd,
  output logic            empty,
  output logic            tend,
  output logic            irq_de,
  output logic            irq_te
);
  sst_edge_t     ev_int, ev_ext, ev;
  logic [DW-1:0] hold_q;
  logic          ld, end_set, busy, sclk_q;

  sst_hold #(.DW(DW)) u_hold (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .load(ld), .end_set(end_set), .de_en(de_en), .te_en(te_en),
    .hold_q(hold_q), .empty(empty), .tend(tend),
    .irq_de(irq_de), .irq_te(irq_te));

  sst_clkgen #(.DIVW(DIVW)) u_gen (
    .clk(clk), .rst_n(rst_n), .busy(busy), .pending(!empty),
    .sclk_q(sclk_q), .div(div), .ev(ev_int));

  sst_extedge #(.SYNC(SYNC)) u_ext (
    .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .ev(ev_ext));

  assign ev = ext_sel ? ev_ext : ev_int;

  sst_shifter #(.DW(DW)) u_shift (
    .clk(clk), .rst_n(rst_n), .ev(ev), .empty(empty), .hold_q(hold_q),
    .load(ld), .end_set(end_set), .busy(busy), .sclk_q(sclk_q), .txd(txd));

  assign wr_ready = empty;
  assign sclk_out = ext_sel ? 1'b1 : sclk_q;

  p_load_refills_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> empty);
  p_txd_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_sel && $past(!ext_sel) && !$stable(txd)) |-> $fell(sclk_out));
endmodule

// File: tb/sim_sync_ser_tx.sv
`timescale 1ns/1ps
module sim_sync_ser_tx;
  logic       clk = 1'b0, rst_n = 1'b0, ext_sel = 1'b0;
  logic [7:0] div = 8'd2;
  logic       de_en = 1'b0, te_en = 1'b0, wr_valid = 1'b0, sclk_in = 1'b1;
  logic [7:0] wr_data = '0;
  logic       wr_ready, sclk_out, txd, empty, tend, irq_de, irq_te;

  int n_tests = 0, n_fail = 0, cyc = 0, pulses = 0, ext_bad = 0;
  bit done = 0;
  int exp_q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sync_ser_tx u0 (.clk(clk), .rst_n(rst_n), .ext_sel(ext_sel), .div(div),
    .de_en(de_en), .te_en(te_en), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_ready(wr_ready), .sclk_in(sclk_in), .sclk_out(sclk_out), .txd(txd),
    .empty(empty), .tend(tend), .irq_de(irq_de), .irq_te(irq_te));

  task automatic chk(string req, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // driver: queue expected byte, then hand it over under valid/ready
  task automatic push(input logic [7:0] b);
    exp_q.push_back(b);
    @(negedge clk);
    wr_valid = 1'b1; wr_data = b;
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic ext_pulses(input int n, input int half);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sclk_in = 1'b0;
      repeat (half) @(negedge clk);
      sclk_in = 1'b1;
      repeat (half) @(negedge clk);
    end
  endtask

  // monitor: assemble bits on rising serial clock, compare against queue
  logic       prev_s = 1'b1;
  logic [7:0] acc = '0;
  int         nb = 0, lowlen = 0;
  always begin
    @(posedge clk); #1;
    if (rst_n) begin
      logic s;
      s = ext_sel ? sclk_in : sclk_out;
      if (ext_sel && !sclk_out) ext_bad++;
      if (!s) lowlen++;
      if (s && !prev_s) begin
        if (!ext_sel) chk("R5", "low half length", lowlen, div + 1);
        lowlen = 0;
        acc = {txd, acc[7:1]};
        nb++; pulses++;
        if (nb == 8) begin
          nb = 0;
          if (exp_q.size() == 0) chk("R4", "unexpected frame", acc, 0);
          else chk("R4", "frame byte lsb-first", acc, exp_q.pop_front());
        end
      end
      prev_s = s;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    int t0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "empty", empty, 1);    chk("R1", "tend", tend, 1);
    chk("R1", "wr_ready", wr_ready, 1);
    chk("R1", "txd", txd, 1);        chk("R1", "sclk_out", sclk_out, 1);
    de_en = 1'b1; te_en = 1'b1;
    @(negedge clk);
    chk("R9", "irq_de with enable", irq_de, 1);
    chk("R9", "irq_te with enable", irq_te, 1);

    // single frame, internal clock, div=2
    exp_q.push_back(8'hA5);
    wr_valid = 1'b1; wr_data = 8'hA5;
    @(negedge clk);
    wr_valid = 1'b0;
    chk("R2", "empty after write", empty, 0);
    chk("R2", "tend after write", tend, 0);
    chk("R9", "irq_de follows empty", irq_de, 0);
    chk("R9", "irq_te follows tend", irq_te, 0);
    @(negedge clk);
    chk("R3", "empty after copy", empty, 1);
    chk("R3", "txd = bit0", txd, 1);
    chk("R3", "sclk_out falls at copy", sclk_out, 0);
    while (!tend) @(negedge clk);
    chk("R8", "txd holds bit7", txd, 1);
    chk("R9", "irq_te on end", irq_te, 1);
    repeat (12) @(negedge clk);
    chk("R8", "txd still bit7", txd, 1);
    chk("R8", "clock idle high", sclk_out, 1);
    chk("R5", "pulses per frame", pulses, 8);

    // chained burst, div=1, back-pressure on third byte
    div = 8'd1; te_en = 1'b0;
    fork
      begin
        push(8'h3C);
        push(8'h81);
        chk("R10", "ready low while byte held", wr_ready, 0);
        push(8'hFF);
      end
      begin
        @(negedge clk);
        while (sclk_out) @(negedge clk);
        t0 = cyc;
        while (!tend) @(negedge clk);
        chk("R7", "burst length in cycles", cyc - t0, 47 * 2);
      end
    join
    repeat (8) @(negedge clk);
    chk("R7", "three chained frames", pulses, 32);
    chk("R8", "txd holds bit7 of 0xFF", txd, 1);

    // external clock mode
    ext_sel = 1'b1; div = 8'd2;
    fork
      begin push(8'h5A); push(8'h0F); end
      begin repeat (10) @(negedge clk); ext_pulses(16, 8); end
    join
    repeat (10) @(negedge clk);
    chk("R6", "no clock driven in external mode", ext_bad, 0);
    chk("R6", "external frames pulses", pulses, 48);
    chk("R8", "ext end flag", tend, 1);
    chk("R8", "ext txd holds bit7 of 0x0F", txd, 0);
    chk("R4", "scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule